// File: doc/BRIEF.md
# Input Capture Register Pair

This block records when an external event happened. A free-running 16-bit counter comes in on a port. A capture input is first passed through a synchronizer, and the block then looks for one edge on it, rising or falling as configured. When that edge is detected, the block copies the counter value into a 16-bit capture register, sets a capture flag and, if enabled, raises an interrupt request.

Software reads the captured value over an 8-bit bus, one byte at a time. Reading the high byte locks out new captures until the low byte is read, so the two bytes always belong to the same event. To clear the flag, software reads the status location and then reads the low byte. A low-byte read without that earlier status read leaves the flag set.

Top module: `icap_pair`

## Requirements
- R1: After reset the flag and the interrupt request are 0. Both capture bytes read as 0. The lock is released and no status read is remembered.
- R2: The capture input passes through two synchronizing flops and one previous-level flop. With `edge_rise_i`=1 a 0-to-1 change captures; with `edge_rise_i`=0 a 1-to-0 change captures. The value captured is `cnt_i` as sampled at the third rising clock edge at which the new input level is present.
- R3: A high-byte read (`rd_stb_i`=1, `rd_sel_i`=1) sets the lock. While the lock is set, edges are ignored and both bytes keep their value. A low-byte read (`rd_sel_i`=2) releases the lock. An edge detected in the same cycle as a high-byte read is also ignored.
- R4: Every accepted capture sets the flag in the following cycle.
- R5: A low-byte read clears the flag only if a status read (`rd_sel_i`=0) came before it. A low-byte read without such a status read leaves the flag set.
- R6: A status read arms the clear. High-byte reads and reads of location 3 leave the arm unchanged. A low-byte read consumes the arm.
- R7: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R8: `rd_data_o` follows `rd_sel_i` combinationally:
  - 0 gives the flag in bit 7, with bits 6..0 at 0.
  - 1 gives the captured high byte.
  - 2 gives the captured low byte.
  - 3 gives 0.
- R9: A low-byte read does not block a capture. An edge detected in the cycle of a low-byte read made while unlocked is captured. In that cycle, setting the flag wins over clearing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 16 | Free-running counter value |
| cap_pin_i | input | 1 | Asynchronous capture input |
| edge_rise_i | input | 1 | 1 selects rising-edge capture, 0 selects falling-edge capture |
| irq_en_i | input | 1 | Capture interrupt enable |
| rd_stb_i | input | 1 | Read strobe, one cycle per access |
| rd_sel_i | input | 2 | Read location: 0 status, 1 high byte, 2 low byte, 3 unused |
| rd_data_o | output | 8 | Read data |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Each internal state shows up at the ports quickly:
- A lock stuck set shows as a stale byte on the next read after an edge, within three cycles of an input change.
- A lock that never sets lets a high read be followed by a low byte from a newer event.
- A wrong arm bit shows on the cycle after a low-byte read, as a flag that stays set or clears when it should not.

The bench compares read data, the flag and the interrupt request against a behavioural model every cycle. A divergence therefore appears in the cycle the bad state first reaches a port.

// File: rtl/icap_pkg.sv
// Shared definitions for the input capture register pair.
// Assumes an 8-bit read bus with four read locations.
package icap_pkg;
    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2,
        SEL_NONE = 2'd3
    } icap_sel_e;
endpackage

// File: rtl/icap_edge.sv
// Synchronizes the capture input and detects one edge of the selected
// polarity. Assumes STAGES >= 2 and an input asynchronous to clk.
module icap_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic rise_sel_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        // Shift the input level through one synchronizer stage.
        always_ff @(posedge clk) begin
            if (!rst_n)      sync_q[g] <= 1'b0;
            else if (g == 0) sync_q[g] <= pin_i;
            else             sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
        end
    end

    // Hold the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Report a single-cycle edge of the configured polarity.
    always_comb begin
        if (rise_sel_i) edge_o = sync_q[STAGES-1] & ~prev_q;
        else            edge_o = ~sync_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/icap_latch.sv
// Holds the captured counter value and the coherency lock.
// Assumes at most one of the read-high and read-low strobes is set per cycle.
module icap_latch #(
    parameter int BYTE_W = 8,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             rd_hi_i,
    input  logic             rd_lo_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             lock_o,
    output logic             take_o
);
    logic [CNT_W-1:0] cap_q;
    logic             lock_q;

    // Accept an edge only when unlocked and not during a high-byte read.
    always_comb take_o = edge_i & ~lock_q & ~rd_hi_i;

    // Copy the counter into the capture register on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (take_o) cap_q <= cnt_i;
    end

    // Set the lock on a high-byte read, release it on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (rd_hi_i) lock_q <= 1'b1;
        else if (rd_lo_i) lock_q <= 1'b0;
    end

    assign cap_o  = cap_q;
    assign lock_o = lock_q;
endmodule

// File: rtl/icap_flag.sv
// Capture flag, its status-read arm and the interrupt request.
// Assumes at most one of the status and low-byte strobes is set per cycle.
module icap_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic rd_stat_i,
    input  logic rd_lo_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic arm_o,
    output logic irq_o
);
    logic flag_q;
    logic arm_q;

    // Set on capture; clear on an armed low-byte read; a capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (take_i)           flag_q <= 1'b1;
        else if (rd_lo_i && arm_q) flag_q <= 1'b0;
    end

    // Remember a status read until the next low-byte read consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         arm_q <= 1'b0;
        else if (rd_stat_i) arm_q <= 1'b1;
        else if (rd_lo_i)   arm_q <= 1'b0;
    end

    // Gate the flag with the interrupt enable.
    always_comb irq_o = flag_q & irq_en_i;

    assign flag_o = flag_q;
    assign arm_o  = arm_q;
endmodule

// File: rtl/icap_pair.sv
// Top of the input capture register pair: read decode, read mux and
// the three sub-blocks. Assumes the read bus presents one access per strobe.
module icap_pair #(
    parameter int BYTE_W = 8,
    parameter int STAGES = 2,
    localparam int CNT_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cap_pin_i,
    input  logic              edge_rise_i,
    input  logic              irq_en_i,
    input  logic              rd_stb_i,
    input  logic [1:0]        rd_sel_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              flag_o,
    output logic              irq_o
);
    import icap_pkg::*;

    icap_sel_e        sel;
    logic             rd_stat, rd_hi, rd_lo;
    logic             edge_det, take, lock_q, arm_q;
    logic [CNT_W-1:0] cap_q;

    // Decode the read location into single-purpose strobes.
    always_comb begin
        sel     = icap_sel_e'(rd_sel_i);
        rd_stat = rd_stb_i && (sel == SEL_STAT);
        rd_hi   = rd_stb_i && (sel == SEL_HI);
        rd_lo   = rd_stb_i && (sel == SEL_LO);
    end

    icap_edge #(.STAGES(STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin_i),
        .rise_sel_i (edge_rise_i),
        .edge_o     (edge_det)
    );

    icap_latch #(.BYTE_W(BYTE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_i  (edge_det),
        .cnt_i   (cnt_i),
        .rd_hi_i (rd_hi),
        .rd_lo_i (rd_lo),
        .cap_o   (cap_q),
        .lock_o  (lock_q),
        .take_o  (take)
    );

    icap_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .rd_stat_i (rd_stat),
        .rd_lo_i   (rd_lo),
        .irq_en_i  (irq_en_i),
        .flag_o    (flag_o),
        .arm_o     (arm_q),
        .irq_o     (irq_o)
    );

    // Select the byte presented on the read bus.
    always_comb begin
        case (sel)
            SEL_STAT: rd_data_o = {flag_o, {(BYTE_W-1){1'b0}}};
            SEL_HI:   rd_data_o = cap_q[CNT_W-1:BYTE_W];
            SEL_LO:   rd_data_o = cap_q[BYTE_W-1:0];
            default:  rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/icap_checker.sv
// Temporal checks on the capture pair, attached to the top by bind.
module icap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_stb_i,
    input logic [1:0]       rd_sel_i,
    input logic             irq_en_i,
    input logic             irq_o,
    input logic             flag_o,
    input logic             take,
    input logic             lock_q,
    input logic             arm_q,
    input logic [CNT_W-1:0] cap_q
);
    logic rd_hi_c, rd_lo_c, rd_other_c;
    always_comb begin
        rd_hi_c    = rd_stb_i && (rd_sel_i == 2'd1);
        rd_lo_c    = rd_stb_i && (rd_sel_i == 2'd2);
        rd_other_c = rd_stb_i && (rd_sel_i == 2'd1 || rd_sel_i == 2'd3);
    end

    p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_c |=> lock_q);
    p_hold_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !rd_lo_c) |=> $stable(cap_q));
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> flag_o);
    p_flag_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !arm_q && !take) |=> flag_o);
    p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_c && arm_q && !take) |=> !flag_o);
    p_arm_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other_c |=> (arm_q == $past(arm_q)));
    p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);
endmodule

bind icap_pair icap_checker #(.CNT_W(CNT_W)) u_icap_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb_i (rd_stb_i),
    .rd_sel_i (rd_sel_i),
    .irq_en_i (irq_en_i),
    .irq_o    (irq_o),
    .flag_o   (flag_o),
    .take     (take),
    .lock_q   (lock_q),
    .arm_q    (arm_q),
    .cap_q    (cap_q)
);

// File: tb/test_icap_pair.sv
module test_icap_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt = 16'h1234;
    logic        pin = 1'b0;
    logic        rise = 1'b1;
    logic        ien = 1'b0;
    logic        stb = 1'b0;
    logic [1:0]  sel = 2'd3;
    logic [7:0]  rd_data;
    logic        flag, irq;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural model state.
    int m_p1, m_p2, m_p3;
    int m_cap, m_lock, m_flag, m_arm;

    always #5 clk = ~clk;

    icap_pair i_icap_pair (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_pin_i(pin),
        .edge_rise_i(rise), .irq_en_i(ien), .rd_stb_i(stb), .rd_sel_i(sel),
        .rd_data_o(rd_data), .flag_o(flag), .irq_o(irq)
    );

    // Counter advances shortly after each edge.
    always @(posedge clk) begin
        #2 cnt = cnt + 16'd7;
    end

    // Reference model updated at each clock edge from stable inputs.
    always @(posedge clk) begin
        int e, take, hi, lo, st;
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_p3 = 0;
            m_cap = 0; m_lock = 0; m_flag = 0; m_arm = 0;
        end else begin
            e    = rise ? (m_p2 == 1 && m_p3 == 0) : (m_p2 == 0 && m_p3 == 1);
            hi   = stb && sel == 2'd1;
            lo   = stb && sel == 2'd2;
            st   = stb && sel == 2'd0;
            take = e && !m_lock && !hi;
            if (take) m_cap = cnt;
            if (hi) m_lock = 1; else if (lo) m_lock = 0;
            if (take) m_flag = 1; else if (lo && m_arm) m_flag = 0;
            if (st) m_arm = 1; else if (lo) m_arm = 0;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = pin;
        end
    end

    function automatic logic [7:0] exp_data(input logic [1:0] s);
        case (s)
            2'd0:    return m_flag ? 8'h80 : 8'h00;
            2'd1:    return m_cap[15:8];
            2'd2:    return m_cap[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every cycle at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 rd_data", rd_data, exp_data(sel));
            check("R4 flag", flag, m_flag);
            check("R7 irq", irq, m_flag && ien);
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic rd(input logic [1:0] s);
        sel = s; stb = 1'b1; step(); stb = 1'b0; sel = 2'd3;
    endtask

    task automatic peek(input string tag, input logic [1:0] s, input int exp);
        sel = s; #1; check(tag, rd_data, exp); sel = 2'd3;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        int saved;
        #(2_000_000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int saved;
        wait_n(3);
        rst_n = 1'b1;
        step();
        // R1: reset state
        peek("R1 hi after reset", 2'd1, 0);
        peek("R1 lo after reset", 2'd2, 0);
        check("R1 flag after reset", flag, 0);
        check("R1 irq after reset", irq, 0);

        // R2: rising capture, value against model
        ien = 1'b1;
        pin = 1'b1; wait_n(4);
        check("R2 rising captured", flag, 1);
        peek("R2 hi byte", 2'd1, m_cap[15:8]);
        check("R7 irq raised", irq, 1);

        // R5: low read without status keeps flag
        rd(2'd2); step();
        check("R5 flag kept without status", flag, 1);
        // R6: status, then high and location 3, then low clears
        rd(2'd0); rd(2'd1); rd(2'd3); rd(2'd2); step();
        check("R6 arm survives other reads", flag, 0);

        // R3: lock holds value across an edge
        pin = 1'b0; wait_n(4);
        rise = 1'b0;
        saved = m_cap;
        rd(2'd1);
        pin = 1'b1; wait_n(2); pin = 1'b0; wait_n(5);
        peek("R3 lo held while locked", 2'd2, saved[7:0]);
        check("R3 no flag while locked", flag, 0);
        rd(2'd2);

        // R2: falling capture after unlock
        pin = 1'b1; wait_n(4); pin = 1'b0; wait_n(4);
        check("R2 falling captured", flag, 1);
        check("R2 new value", m_cap != saved, 1);

        // R9: edge in same cycle as low read, after status read
        rd(2'd0);
        pin = 1'b1; wait_n(4);
        pin = 1'b0; step(); step();
        rd(2'd2); step();
        check("R9 capture wins over clear", flag, 1);

        // R3: edge coincident with a high-byte read is ignored
        rd(2'd0); rd(2'd2); step();
        check("R5 cleared", flag, 0);
        pin = 1'b1; wait_n(4);
        pin = 1'b0; step(); step();
        rd(2'd1); step();
        check("R3 coincident edge ignored", flag, 0);
        rd(2'd2);

        // R7: masked interrupt
        ien = 1'b0;
        pin = 1'b1; wait_n(4); pin = 1'b0; wait_n(4);
        check("R7 irq masked", irq, 0);
        peek("R8 status bit7", 2'd0, 8'h80);
        peek("R8 location 3 zero", 2'd3, 0);

        wait_n(20);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule